// File: doc/BRIEF.md
# Bayer Centre-Window Brightness Controller

This block closes the exposure loop of a small image sensor. It watches the raw Bayer pixel stream as it comes out of the sensor receiver. It takes only the green samples that fall inside a fixed square window at the middle of the frame and sums them. When the last pixel of a complete frame arrives, it turns the sum into an average. It then steps an illumination level up or down so that the next frame's brightness moves back inside a band set by two thresholds.

The stream carries one pixel per valid cycle and three markers. `sof_i` flags the first pixel of a frame, `eol_i` flags the last pixel of each line and `eof_i` flags the last pixel of the frame. The design tracks the row and column itself, so it needs no address inputs. The frame size, the window size, the pixel width and the level width are parameters. The window is always centred, and the number of green samples in it must be a power of two. The default configuration is a 320×240 frame, a 128×128 window and 10-bit samples.

Top module: `bayer_bright_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `illum_o` equals `LVL_INIT` (default 8).
- R2: Only pixels in columns X0..X0+WIN_W-1 and rows Y0..Y0+WIN_H-1 contribute, where X0=(IMG_W-WIN_W)/2 and Y0=(IMG_H-WIN_H)/2, both counted from zero (defaults: columns 96..223, rows 56..183).
- R3: Only green sites count, meaning those where row+column is even. Red and blue sites (row+column odd) have no effect on the level.
- R4: The average is the window's green sum shifted right by log2(WIN_W*WIN_H/2), with the fractional part dropped (default: 23-bit sum shifted right by 13).
- R5: At a completed frame end, an average strictly below `lo_thr_i` raises `illum_o` by one. This case is tested first, so it wins when the thresholds cross.
- R6: At a completed frame end, an average strictly above `hi_thr_i` (and not below `lo_thr_i`) lowers `illum_o` by one.
- R7: An average from `lo_thr_i` to `hi_thr_i` inclusive leaves `illum_o` unchanged.
- R8: `illum_o` saturates at 0 and at 2^LVL_W-1. It never wraps.
- R9: A pixel carrying `sof_i` restarts the frame: the row and column go to zero and the sum restarts with that pixel, so partial data from before it is discarded.
- R10: An `eof_i` on any pixel other than row IMG_H-1, column IMG_W-1 of a frame opened by `sof_i` does not change the level.
- R11: `illum_o` changes only in the cycle after a valid pixel carrying `eof_i`, and it is stable otherwise, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | A pixel is present this cycle |
| pix_data_i | input | PIX_W | Raw Bayer sample |
| sof_i | input | 1 | First pixel of a frame |
| eol_i | input | 1 | Last pixel of a line |
| eof_i | input | 1 | Last pixel of a frame |
| lo_thr_i | input | PIX_W | Lower edge of the target band |
| hi_thr_i | input | PIX_W | Upper edge of the target band |
| illum_o | output | LVL_W | Illumination level for the LED driver |

## Verification
The bench goes after the window edges and the colour sites. It drives saturated values outside the window and on red and blue sites against in-window green values that pull the other way. A design with an off-by-one window or a wrong green parity would then step in the wrong direction. It checks a non-uniform pattern with thresholds set exactly at, one above and one below the truncated average, which catches a wrong shift or rounding. It checks averages equal to each threshold (a strict versus inclusive compare), crossed thresholds, runs into both saturation limits (a wrapping counter would jump to the far end), an early end of frame (a design that updates anyway) and a restart in the middle of a frame (a design that does not clear its sum would carry stale brightness into the next frame).

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/bbc_pos.sv
module bbc_pos #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int WIN_W = 128,
  parameter int WIN_H = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eol_i,
  input  logic eof_i,
  output logic take_o,
  output logic done_o
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);
  localparam int X0 = (IMG_W - WIN_W) / 2;
  localparam int Y0 = (IMG_H - WIN_H) / 2;
  localparam logic [CW-1:0] X_LO   = CW'(X0);
  localparam logic [CW-1:0] X_HI   = CW'(X0 + WIN_W - 1);
  localparam logic [RW-1:0] Y_LO   = RW'(Y0);
  localparam logic [RW-1:0] Y_HI   = RW'(Y0 + WIN_H - 1);
  localparam logic [CW-1:0] C_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] R_LAST = RW'(IMG_H - 1);

  logic [CW-1:0] col_q, col_c;
  logic [RW-1:0] row_q, row_c;
  logic          open_q, open_c;
  logic          in_win, green, last_px;

  // position of the pixel on the bus now; sof forces origin
  assign col_c  = sof_i ? '0 : col_q;
  assign row_c  = sof_i ? '0 : row_q;
  assign open_c = sof_i | open_q;

  assign in_win  = (col_c >= X_LO) && (col_c <= X_HI) &&
                   (row_c >= Y_LO) && (row_c <= Y_HI);
  assign green   = ~(col_c[0] ^ row_c[0]);
  assign last_px = (col_c == C_LAST) && (row_c == R_LAST);

  assign take_o = valid_i & in_win & green;
  assign done_o = valid_i & eof_i & open_c & last_px;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      row_q  <= '0;
      open_q <= 1'b0;
    end else if (valid_i) begin
      if (eol_i) begin
        col_q <= '0;
        row_q <= row_c + 1'b1;
      end else begin
        col_q <= col_c + 1'b1;
        row_q <= row_c;
      end
      open_q <= open_c & ~eof_i;
    end
  end
endmodule

// File: rtl/bbc_accum.sv
module bbc_accum #(
  parameter int PIX_W = 10,
  parameter int SUM_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             take_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [SUM_W-1:0] sum_nxt_o
);
  logic [SUM_W-1:0] sum_q, sum_c;

  assign sum_c     = (valid_i && sof_i) ? '0 : sum_q;
  assign sum_nxt_o = take_i ? sum_c + SUM_W'(pix_i) : sum_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (valid_i) sum_q <= sum_nxt_o;
  end
endmodule

// File: rtl/bbc_level.sv
module bbc_level
  import bbc_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int LVL_W    = 4,
  parameter int LVL_INIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [PIX_W-1:0] avg_i,
  input  logic [PIX_W-1:0] lo_i,
  input  logic [PIX_W-1:0] hi_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  adj_e adj;

  always_comb begin
    adj = ADJ_HOLD;
    if (avg_i < lo_i)      adj = ADJ_UP;
    else if (avg_i > hi_i) adj = ADJ_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= LVL_W'(LVL_INIT);
    end else if (done_i) begin
      unique case (adj)
        ADJ_UP:   if (level_o != LVL_MAX) level_o <= level_o + 1'b1;
        ADJ_DOWN: if (level_o != '0)      level_o <= level_o - 1'b1;
        default:  level_o <= level_o;
      endcase
    end
  end
endmodule

// File: rtl/bayer_bright_ctrl.sv
module bayer_bright_ctrl #(
  parameter int IMG_W    = 320,
  parameter int IMG_H    = 240,
  parameter int WIN_W    = 128,
  parameter int WIN_H    = 128,
  parameter int PIX_W    = 10,
  parameter int LVL_W    = 4,
  parameter int LVL_INIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic             eof_i,
  input  logic [PIX_W-1:0] lo_thr_i,
  input  logic [PIX_W-1:0] hi_thr_i,
  output logic [LVL_W-1:0] illum_o
);
  localparam int GREEN_N = WIN_W * WIN_H / 2;
  localparam int SH      = $clog2(GREEN_N);
  localparam int SUM_W   = PIX_W + SH;

  logic             take;
  logic             frame_done;
  logic [SUM_W-1:0] sum_nxt;
  logic [PIX_W-1:0] avg;

  bbc_pos #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H)
  ) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(pix_valid_i),
    .sof_i  (sof_i),
    .eol_i  (eol_i),
    .eof_i  (eof_i),
    .take_o (take),
    .done_o (frame_done)
  );

  bbc_accum #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (pix_valid_i),
    .sof_i    (sof_i),
    .take_i   (take),
    .pix_i    (pix_data_i),
    .sum_nxt_o(sum_nxt)
  );

  assign avg = sum_nxt[SUM_W-1:SH];

  bbc_level #(.PIX_W(PIX_W), .LVL_W(LVL_W), .LVL_INIT(LVL_INIT)) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (frame_done),
    .avg_i  (avg),
    .lo_i   (lo_thr_i),
    .hi_i   (hi_thr_i),
    .level_o(illum_o)
  );
endmodule

// File: rtl/bbc_chk.sv
module bbc_chk #(
  parameter int PIX_W = 10,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             eof_i,
  input logic [PIX_W-1:0] lo_thr_i,
  input logic [PIX_W-1:0] hi_thr_i,
  input logic             frame_done,
  input logic [PIX_W-1:0] avg,
  input logic [LVL_W-1:0] illum_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  // R5
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && (avg < lo_thr_i) && (illum_o != LVL_MAX))
    |=> (illum_o == LVL_W'($past(illum_o) + 1'b1)));

  // R6
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && (avg >= lo_thr_i) && (avg > hi_thr_i) && (illum_o != '0))
    |=> (illum_o == LVL_W'($past(illum_o) - 1'b1)));

  // R7
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && (avg >= lo_thr_i) && (avg <= hi_thr_i)) |=> $stable(illum_o));

  // R8
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illum_o == LVL_MAX) |=> (illum_o != '0));

  // R8
  sat_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illum_o == '0) |=> (illum_o != LVL_MAX));

  // R10
  early_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && eof_i && !frame_done) |=> $stable(illum_o));

  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_valid_i && eof_i) |=> $stable(illum_o));
endmodule

bind bayer_bright_ctrl bbc_chk #(.PIX_W(PIX_W), .LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .eof_i      (eof_i),
  .lo_thr_i   (lo_thr_i),
  .hi_thr_i   (hi_thr_i),
  .frame_done (frame_done),
  .avg        (avg),
  .illum_o    (illum_o)
);

// File: tb/bayer_bright_ctrl_tb_top.sv
module bayer_bright_ctrl_tb_top;
  localparam int IMG_W = 16;
  localparam int IMG_H = 12;
  localparam int WIN_W = 8;
  localparam int WIN_H = 8;
  localparam int X0    = (IMG_W - WIN_W) / 2;
  localparam int Y0    = (IMG_H - WIN_H) / 2;
  localparam int SH    = 5;  // log2(8*8/2)
  localparam int LVL_MAX = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [9:0] pix_data = '0;
  logic       sof = 1'b0, eol = 1'b0, eof = 1'b0;
  logic [9:0] lo_thr = '0, hi_thr = '0;
  logic [3:0] illum;

  int n_chk = 0;
  int n_fail = 0;
  int exp_lvl;

  always #5 clk = ~clk;

  bayer_bright_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .PIX_W(10), .LVL_W(4), .LVL_INIT(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .sof_i(sof), .eol_i(eol), .eof_i(eof),
    .lo_thr_i(lo_thr), .hi_thr_i(hi_thr), .illum_o(illum)
  );

  // table: in-window green, red/blue, outside-window, lo, hi, expected level
  localparam int NV = 8;
  localparam int V_G  [NV] = '{100, 250, 400, 200, 300, 301, 199, 500};
  localparam int V_RB [NV] = '{1023,  0,   0, 1023,   0, 1023, 0,   0};
  localparam int V_OUT[NV] = '{1023,  0,   0,    0, 1023,  0, 1023, 0};
  localparam int V_LO [NV] = '{200, 200, 200, 200, 200, 200, 200, 600};
  localparam int V_HI [NV] = '{300, 300, 300, 300, 300, 300, 300, 100};
  localparam int V_EXP[NV] = '{  9,   9,   8,   8,   8,   7,   8,   9};

  task automatic check(input int act, input int expv, input string req);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int pat_val(input int r, input int c);
    return (c * 7 + r * 13) % 1024;
  endfunction

  function automatic int pat_avg();
    int s = 0;
    for (int r = Y0; r < Y0 + WIN_H; r++)
      for (int c = X0; c < X0 + WIN_W; c++)
        if (((r + c) % 2) == 0) s += pat_val(r, c);
    return s >> SH;
  endfunction

  // stop_row < 0: full frame; otherwise stop after that row, with eof if give_eof
  task automatic send_frame(input int g, input int rb, input int outv,
                            input int lo, input int hi, input bit pat,
                            input int stop_row, input bit give_eof);
    lo_thr = 10'(lo);
    hi_thr = 10'(hi);
    for (int r = 0; r < IMG_H; r++) begin
      for (int c = 0; c < IMG_W; c++) begin
        bit inw;
        int v;
        @(negedge clk);
        inw = (c >= X0) && (c < X0 + WIN_W) && (r >= Y0) && (r < Y0 + WIN_H);
        if (!inw) v = outv;
        else if (((r + c) % 2) != 0) v = rb;
        else v = pat ? pat_val(r, c) : g;
        pix_valid = 1'b1;
        pix_data  = 10'(v);
        sof = (r == 0) && (c == 0);
        eol = (c == IMG_W - 1);
        eof = ((r == IMG_H - 1) && (c == IMG_W - 1)) ||
              (give_eof && (r == stop_row) && (c == IMG_W - 1));
      end
      if (stop_row >= 0 && r == stop_row) break;
    end
    @(negedge clk);
    pix_valid = 1'b0;
    sof = 1'b0; eol = 1'b0; eof = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int pa;
    repeat (3) @(negedge clk);
    check(int'(illum), 8, "R1 level during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(illum), 8, "R1 level after reset");

    // R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      send_frame(V_G[i], V_RB[i], V_OUT[i], V_LO[i], V_HI[i], 1'b0, -1, 1'b0);
      check(int'(illum), V_EXP[i], $sformatf("R2/R3/R5/R6/R7 vector %0d", i));
    end
    exp_lvl = 9;

    // R4 truncated average of a non-uniform pattern
    pa = pat_avg();
    send_frame(0, 1023, 0, pa, pa, 1'b1, -1, 1'b0);
    check(int'(illum), exp_lvl, "R4 avg equals both thresholds, hold");
    send_frame(0, 1023, 0, pa + 1, 1023, 1'b1, -1, 1'b0);
    exp_lvl++;
    check(int'(illum), exp_lvl, "R4 avg one below low, up");
    send_frame(0, 0, 1023, 0, pa - 1, 1'b1, -1, 1'b0);
    exp_lvl--;
    check(int'(illum), exp_lvl, "R4 avg one above high, down");

    // R10 early eof does not update
    send_frame(0, 0, 0, 200, 300, 1'b0, 6, 1'b1);
    check(int'(illum), exp_lvl, "R10 early eof ignored");

    // R11 level stable mid-frame, then R9 restart clears the sum
    send_frame(1023, 1023, 1023, 200, 300, 1'b0, 8, 1'b0);
    check(int'(illum), exp_lvl, "R11 stable in mid frame");
    send_frame(250, 0, 0, 200, 300, 1'b0, -1, 1'b0);
    check(int'(illum), exp_lvl, "R9 restart discards partial sum");

    // R8 saturation at top
    while (exp_lvl < LVL_MAX) begin
      send_frame(0, 0, 0, 10, 20, 1'b0, -1, 1'b0);
      exp_lvl++;
      check(int'(illum), exp_lvl, "R5 step toward top");
    end
    for (int k = 0; k < 2; k++) begin
      send_frame(0, 0, 0, 10, 20, 1'b0, -1, 1'b0);
      check(int'(illum), LVL_MAX, "R8 saturate at top");
    end

    // R8 saturation at bottom
    while (exp_lvl > 0) begin
      send_frame(1023, 0, 0, 10, 20, 1'b0, -1, 1'b0);
      exp_lvl--;
      check(int'(illum), exp_lvl, "R6 step toward bottom");
    end
    for (int k = 0; k < 2; k++) begin
      send_frame(1023, 0, 0, 10, 20, 1'b0, -1, 1'b0);
      check(int'(illum), 0, "R8 saturate at bottom");
    end

    // R1 reset mid-run restores initial level
    rst_n = 1'b0;
    @(negedge clk);
    check(int'(illum), 8, "R1 reset restores level");
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule